// File: doc/BRIEF.md
# Subroutine and interrupt stack sequencer

This block runs the stack traffic behind the control-transfer instructions of an 8-bit CPU. It is given an already decoded opcode, up to two operand bytes and the current register set: PC, SP, CC, A, B, IX and IY. On a start strobe it works out where control goes next. It then moves bytes one at a time through a single byte-wide memory port to build or unwind a frame on a stack that grows downward. When it finishes it presents the new PC, SP and the register values.

The block handles five instruction groups. Calls come in four addressing forms: direct page, indexed by X or Y, 16-bit extended, and relative branch. The other groups are return-from-subroutine, software interrupt, wait-for-interrupt and return-from-interrupt. The software interrupt fetches its vector from a 16-bit address supplied by the core. Wait-for-interrupt fetches the same vector once an interrupt request arrives. Each memory access takes exactly one cycle, and the read data is taken in the same cycle that the address is driven. All address and stack-pointer arithmetic wraps modulo 65536.

`pc_i` is the address of the first byte of the instruction, which is the prefix byte when a prefix is present.

Top module: `stack_sq`

## Requirements
- R1: Opcode 0x9D (no prefix) is a direct call. The target is {0x00, opr0}.
- R2: Opcode 0xAD is an indexed call. The target is IX + opr0 when `prefix_y_i`=0, or IY + opr0 when `prefix_y_i`=1. opr0 is unsigned, and the sum wraps at 16 bits.
- R3: Opcode 0xBD is an extended call. The target is {opr0, opr1}.
- R4: Opcode 0x8D is a relative call. The target is PC + 2 + sign-extended opr0.
- R5: Every call writes the return-address low byte at SP and then the high byte at SP-1. It ends with SP-2. The return address is PC + 2 for 0x9D, 0x8D and unprefixed 0xAD, and PC + 3 for 0xBD and prefixed 0xAD. A call completes with `done_o` in the third cycle after the start edge.
- R6: Opcode 0x39 reads PC high from SP+1 and PC low from SP+2. It ends with SP+2 and completes in the third cycle.
- R7: Opcode 0x3F writes nine bytes at SP, SP-1, … SP-8 in this order: return low, return high, IY low, IY high, IX low, IX high, A, B, CC. The return address is PC+1, the stacked CC is the value before the instruction, and SP ends at SP-9.
- R8: After stacking its frame, opcode 0x3F sets CC bit 4, the interrupt mask. It then reads the PC high byte at `vec_addr_i` and the low byte at `vec_addr_i`+1, and completes in the twelfth cycle.
- R9: Opcode 0x3B reads SP+1 … SP+9 into CC, B, A, IX high, IX low, IY high, IY low, PC high and PC low, in that order. It ends with SP+9 and completes in the tenth cycle.
- R10: Opcode 0x3E stacks the same frame as R7 with return address PC+1. It then stays busy with no memory access until `irq_i` is high. After that it sets CC bit 4, fetches the vector as in R8, and completes in the third cycle after the cycle where `irq_i` was sampled high.
- R11: `busy_o` is high from the cycle after the start edge through the `done_o` cycle. `done_o` is a one-cycle pulse. Any other opcode, and a set prefix with any opcode other than 0xAD, completes in the first cycle with no memory access and with PC and SP unchanged.
- R12: Stack addresses and the final SP wrap modulo 65536 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when idle |
| opcode_i | input | 8 | Decoded opcode byte |
| prefix_y_i | input | 1 | Y-index prefix preceded the opcode |
| opr0_i | input | 8 | First operand byte |
| opr1_i | input | 8 | Second operand byte |
| pc_i | input | 16 | Address of the instruction's first byte |
| sp_i | input | 16 | Stack pointer |
| cc_i | input | 8 | Condition codes |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| ix_i | input | 16 | Index register X |
| iy_i | input | 16 | Index register Y |
| vec_addr_i | input | 16 | Address of the interrupt vector |
| irq_i | input | 1 | Interrupt request, ends the wait state |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | 8 | Memory read data, same cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Resulting PC |
| sp_o | output | 16 | Resulting SP |
| cc_o | output | 8 | Resulting CC |
| a_o | output | 8 | Resulting A |
| b_o | output | 8 | Resulting B |
| ix_o | output | 16 | Resulting IX |
| iy_o | output | 16 | Resulting IY |

## Verification
The bench sweeps all 256 operand values for the direct, X, Y and relative call forms. It uses base addresses that carry into the high byte and wrap past 0xFFFF, so a design that drops the index carry or zero-extends the branch offset produces wrong targets. It checks the byte at every frame slot for the call and both interrupt frames, and restores an RTI frame from known bytes. A swapped order or an off-by-one stack pointer therefore shows up as a miscompare at a named address. The stack pointer is placed at 0x0000 and near 0xFFFF, and wait-for-interrupt is held off for many cycles. This catches a design that fails to wrap, that leaks accesses while waiting, or that leaves the wait state early. Unknown opcodes must complete at once without touching memory.

// File: rtl/stack_sq_pkg.sv
`timescale 1ns/1ps
package stack_sq_pkg;
  localparam int unsigned AW      = 16;
  localparam int unsigned BW      = 8;
  localparam int unsigned CNT_W   = 4;
  localparam int unsigned FRAME_N = 9;
  localparam int unsigned CALL_N  = 2;
  localparam int unsigned IBIT    = 4;

  localparam logic [BW-1:0] OP_CALL_DIR = 8'h9D;
  localparam logic [BW-1:0] OP_CALL_IDX = 8'hAD;
  localparam logic [BW-1:0] OP_CALL_EXT = 8'hBD;
  localparam logic [BW-1:0] OP_CALL_REL = 8'h8D;
  localparam logic [BW-1:0] OP_RET_SUB  = 8'h39;
  localparam logic [BW-1:0] OP_RET_INT  = 8'h3B;
  localparam logic [BW-1:0] OP_SW_INT   = 8'h3F;
  localparam logic [BW-1:0] OP_WAIT     = 8'h3E;

  typedef enum logic [2:0] {K_NONE, K_CALL, K_RTS, K_SWI, K_WAI, K_RTI} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_PULL, S_WAIT, S_VECH, S_VECL, S_FIN} state_e;
endpackage

// File: rtl/stack_sq_decode.sv
`timescale 1ns/1ps
module stack_sq_decode
  import stack_sq_pkg::*;
(
  input  logic [BW-1:0]    opcode_i,
  input  logic             pfx_i,
  input  logic [BW-1:0]    opr0_i,
  input  logic [BW-1:0]    opr1_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    ix_i,
  input  logic [AW-1:0]    iy_i,
  output kind_e            kind_o,
  output logic [CNT_W-1:0] nbytes_o,
  output logic [AW-1:0]    target_o,
  output logic [AW-1:0]    ret_o
);
  logic [AW-1:0] len;
  logic [AW-1:0] off_u, off_s;

  assign off_u = {{(AW-BW){1'b0}}, opr0_i};
  assign off_s = {{(AW-BW){opr0_i[BW-1]}}, opr0_i};

  always_comb begin
    kind_o   = K_NONE;
    nbytes_o = '0;
    target_o = '0;
    len      = AW'(1);
    if (pfx_i) begin
      if (opcode_i == OP_CALL_IDX) begin
        kind_o = K_CALL; nbytes_o = CNT_W'(CALL_N);
        target_o = iy_i + off_u; len = AW'(3);
      end
    end else begin
      unique case (opcode_i)
        OP_CALL_DIR: begin
          kind_o = K_CALL; nbytes_o = CNT_W'(CALL_N);
          target_o = off_u; len = AW'(2);
        end
        OP_CALL_IDX: begin
          kind_o = K_CALL; nbytes_o = CNT_W'(CALL_N);
          target_o = ix_i + off_u; len = AW'(2);
        end
        OP_CALL_EXT: begin
          kind_o = K_CALL; nbytes_o = CNT_W'(CALL_N);
          target_o = {opr0_i, opr1_i}; len = AW'(3);
        end
        OP_CALL_REL: begin
          kind_o = K_CALL; nbytes_o = CNT_W'(CALL_N);
          target_o = pc_i + AW'(2) + off_s; len = AW'(2);
        end
        OP_RET_SUB: begin kind_o = K_RTS; nbytes_o = CNT_W'(CALL_N);  end
        OP_RET_INT: begin kind_o = K_RTI; nbytes_o = CNT_W'(FRAME_N); end
        OP_SW_INT:  begin kind_o = K_SWI; nbytes_o = CNT_W'(FRAME_N); end
        OP_WAIT:    begin kind_o = K_WAI; nbytes_o = CNT_W'(FRAME_N); end
        default: ;
      endcase
    end
  end

  assign ret_o = pc_i + len;
endmodule

// File: rtl/stack_sq_frame.sv
`timescale 1ns/1ps
module stack_sq_frame
  import stack_sq_pkg::*;
(
  input  logic [CNT_W-1:0] slot_i,
  input  logic [AW-1:0]    ret_i,
  input  logic [AW-1:0]    iy_i,
  input  logic [AW-1:0]    ix_i,
  input  logic [BW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  input  logic [BW-1:0]    cc_i,
  output logic [BW-1:0]    byte_o
);
  // slot = push index; slot k lives at SP-k
  always_comb begin
    unique case (slot_i)
      4'd0:    byte_o = ret_i[BW-1:0];
      4'd1:    byte_o = ret_i[AW-1:BW];
      4'd2:    byte_o = iy_i[BW-1:0];
      4'd3:    byte_o = iy_i[AW-1:BW];
      4'd4:    byte_o = ix_i[BW-1:0];
      4'd5:    byte_o = ix_i[AW-1:BW];
      4'd6:    byte_o = a_i;
      4'd7:    byte_o = b_i;
      4'd8:    byte_o = cc_i;
      default: byte_o = '0;
    endcase
  end
endmodule

// File: rtl/stack_sq.sv
`timescale 1ns/1ps
module stack_sq
  import stack_sq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic          prefix_y_i,
  input  logic [7:0]    opr0_i,
  input  logic [7:0]    opr1_i,
  input  logic [15:0]   pc_i,
  input  logic [15:0]   sp_i,
  input  logic [7:0]    cc_i,
  input  logic [7:0]    a_i,
  input  logic [7:0]    b_i,
  input  logic [15:0]   ix_i,
  input  logic [15:0]   iy_i,
  input  logic [15:0]   vec_addr_i,
  input  logic          irq_i,
  output logic [15:0]   mem_addr_o,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_re_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [15:0]   pc_o,
  output logic [15:0]   sp_o,
  output logic [7:0]    cc_o,
  output logic [7:0]    a_o,
  output logic [7:0]    b_o,
  output logic [15:0]   ix_o,
  output logic [15:0]   iy_o
);
  state_e           state_q;
  kind_e            kind_q, dec_kind;
  logic [CNT_W-1:0] n_q, cnt_q, dec_n, slot;
  logic [AW-1:0]    pc_q, tgt_q, sp_q, vec_q, ix_q, iy_q, dec_tgt, dec_ret;
  logic [BW-1:0]    cc_q, a_q, b_q, frame_byte;
  logic             last;

  stack_sq_decode u_dec (
    .opcode_i (opcode_i), .pfx_i (prefix_y_i), .opr0_i (opr0_i), .opr1_i (opr1_i),
    .pc_i (pc_i), .ix_i (ix_i), .iy_i (iy_i),
    .kind_o (dec_kind), .nbytes_o (dec_n), .target_o (dec_tgt), .ret_o (dec_ret)
  );

  // pulls walk the frame from the top slot down
  assign slot = (state_q == S_PULL) ? (n_q - CNT_W'(1) - cnt_q) : cnt_q;
  assign last = (cnt_q == n_q - CNT_W'(1));

  stack_sq_frame u_frm (
    .slot_i (slot), .ret_i (pc_q), .iy_i (iy_q), .ix_i (ix_q),
    .a_i (a_q), .b_i (b_q), .cc_i (cc_q), .byte_o (frame_byte)
  );

  always_comb begin
    unique case (state_q)
      S_PUSH:  mem_addr_o = sp_q - AW'(cnt_q);
      S_PULL:  mem_addr_o = sp_q + AW'(1) + AW'(cnt_q);
      S_VECH:  mem_addr_o = vec_q;
      S_VECL:  mem_addr_o = vec_q + AW'(1);
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_we_o    = (state_q == S_PUSH);
  assign mem_wdata_o = frame_byte;
  assign mem_re_o    = (state_q == S_PULL) || (state_q == S_VECH) || (state_q == S_VECL);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign pc_o = pc_q;  assign sp_o = sp_q;  assign cc_o = cc_q;
  assign a_o  = a_q;   assign b_o  = b_q;
  assign ix_o = ix_q;  assign iy_o = iy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; kind_q <= K_NONE; n_q <= '0; cnt_q <= '0;
      pc_q <= '0; tgt_q <= '0; sp_q <= '0; vec_q <= '0;
      cc_q <= '0; a_q <= '0; b_q <= '0; ix_q <= '0; iy_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          kind_q <= dec_kind; n_q <= dec_n; cnt_q <= '0;
          tgt_q <= dec_tgt; sp_q <= sp_i; vec_q <= vec_addr_i;
          cc_q <= cc_i; a_q <= a_i; b_q <= b_i; ix_q <= ix_i; iy_q <= iy_i;
          pc_q <= (dec_kind == K_NONE) ? pc_i : dec_ret;
          unique case (dec_kind)
            K_NONE:        state_q <= S_FIN;
            K_RTS, K_RTI:  state_q <= S_PULL;
            default:       state_q <= S_PUSH;
          endcase
        end
        S_PUSH: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last) begin
            cnt_q <= '0;
            sp_q  <= sp_q - AW'(n_q);
            unique case (kind_q)
              K_CALL:  begin pc_q <= tgt_q; state_q <= S_FIN; end
              K_SWI:   begin cc_q[IBIT] <= 1'b1; state_q <= S_VECH; end
              default: state_q <= S_WAIT;
            endcase
          end
        end
        S_WAIT: if (irq_i) begin
          cc_q[IBIT] <= 1'b1;
          state_q    <= S_VECH;
        end
        S_VECH: begin pc_q[AW-1:BW] <= mem_rdata_i; state_q <= S_VECL; end
        S_VECL: begin pc_q[BW-1:0]  <= mem_rdata_i; state_q <= S_FIN;  end
        S_PULL: begin
          unique case (slot)
            4'd0: pc_q[BW-1:0]  <= mem_rdata_i;
            4'd1: pc_q[AW-1:BW] <= mem_rdata_i;
            4'd2: iy_q[BW-1:0]  <= mem_rdata_i;
            4'd3: iy_q[AW-1:BW] <= mem_rdata_i;
            4'd4: ix_q[BW-1:0]  <= mem_rdata_i;
            4'd5: ix_q[AW-1:BW] <= mem_rdata_i;
            4'd6: a_q           <= mem_rdata_i;
            4'd7: b_q           <= mem_rdata_i;
            4'd8: cc_q          <= mem_rdata_i;
            default: ;
          endcase
          cnt_q <= cnt_q + CNT_W'(1);
          if (last) begin
            cnt_q   <= '0;
            sp_q    <= sp_q + AW'(n_q);
            state_q <= S_FIN;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r11_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && !mem_re_o));
  a_r5_push_descends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == 16'($past(mem_addr_o) - 16'd1)));
  a_r9_pull_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PULL && $past(state_q == S_PULL)) |-> (mem_addr_o == 16'($past(mem_addr_o) + 16'd1)));
  a_r8_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (kind_q == K_SWI || kind_q == K_WAI)) |-> cc_o[IBIT]);
  a_r10_wait_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) |-> (!mem_we_o && !mem_re_o && !done_o));
endmodule

// File: tb/sim_stack_sq.sv
`timescale 1ns/1ps
module sim_stack_sq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pfx = 1'b0, irq = 1'b0;
  logic [7:0] op = 8'h00, o0 = 8'h00, o1 = 8'h00, cc = 8'h00, ra = 8'h00, rb = 8'h00;
  logic [15:0] pc = 16'h0, sp = 16'h0, ix = 16'h0, iy = 16'h0, vec = 16'h0040;
  logic [15:0] maddr, pc_o, sp_o, ix_o, iy_o;
  logic [7:0] wdata, rdata, cc_o, a_o, b_o;
  logic we, re, busy, done;
  logic [7:0] mem [256];
  int vecs = 0, fails = 0, nwr = 0;

  always #2.5 clk = ~clk;

  stack_sq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(op), .prefix_y_i(pfx),
    .opr0_i(o0), .opr1_i(o1), .pc_i(pc), .sp_i(sp), .cc_i(cc), .a_i(ra), .b_i(rb),
    .ix_i(ix), .iy_i(iy), .vec_addr_i(vec), .irq_i(irq),
    .mem_addr_o(maddr), .mem_we_o(we), .mem_wdata_o(wdata), .mem_re_o(re),
    .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .pc_o(pc_o), .sp_o(sp_o),
    .cc_o(cc_o), .a_o(a_o), .b_o(b_o), .ix_o(ix_o), .iy_o(iy_o)
  );

  assign rdata = mem[maddr[7:0]];
  always @(posedge clk) if (we) begin mem[maddr[7:0]] <= wdata; nwr <= nwr + 1; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(output int cyc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
  endtask

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem[a[7:0]];
  endfunction

  task automatic call_chk(input string req, input logic [15:0] tgt, input logic [15:0] ret);
    int cyc;
    run(cyc);
    check({req, " target"}, pc_o, tgt);
    check("R5 sp", sp_o, 16'(sp - 16'd2));
    check("R5 ret lo at sp", rd(sp), ret[7:0]);
    check("R5 ret hi at sp-1", rd(16'(sp - 16'd1)), ret[15:8]);
    check("R5 cycles", cyc, 3);
  endtask

  task automatic frame_chk(input string req, input logic [15:0] s, input logic [15:0] ret);
    check({req, " ret lo"}, rd(s), ret[7:0]);
    check({req, " ret hi"}, rd(16'(s - 1)), ret[15:8]);
    check({req, " iy lo"},  rd(16'(s - 2)), iy[7:0]);
    check({req, " iy hi"},  rd(16'(s - 3)), iy[15:8]);
    check({req, " ix lo"},  rd(16'(s - 4)), ix[7:0]);
    check({req, " ix hi"},  rd(16'(s - 5)), ix[15:8]);
    check({req, " a"},      rd(16'(s - 6)), ra);
    check({req, " b"},      rd(16'(s - 7)), rb);
    check({req, " cc"},     rd(16'(s - 8)), cc);
    check({req, " sp"},     sp_o, 16'(s - 9));
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    int cyc, w0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h40] = 8'hC3; mem[8'h41] = 8'h5A;
    repeat (3) @(negedge clk);
    check("R11 reset busy", busy, 0);
    check("R11 reset done", done, 0);
    check("R11 reset we", we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    sp = 16'h00A0;
    // R1 direct
    for (int v = 0; v < 256; v++) begin
      op = 8'h9D; pfx = 0; o0 = 8'(v); pc = 16'h1234 + 16'(v * 7);
      call_chk("R1", {8'h00, o0}, 16'(pc + 2));
    end
    // R2 indexed X and Y
    ix = 16'hFF80; iy = 16'h12F0;
    for (int v = 0; v < 256; v++) begin
      op = 8'hAD; pfx = 0; o0 = 8'(v); pc = 16'h4000 + 16'(v);
      call_chk("R2 X", 16'(ix + {8'h00, o0}), 16'(pc + 2));
      pfx = 1;
      call_chk("R2 Y", 16'(iy + {8'h00, o0}), 16'(pc + 3));
    end
    pfx = 0;
    // R3 extended
    for (int v = 0; v < 64; v++) begin
      op = 8'hBD; o0 = 8'(v * 37 + 1); o1 = 8'(v * 91 + 5); pc = 16'hFFFD - 16'(v);
      call_chk("R3", {o0, o1}, 16'(pc + 3));
    end
    // R4 relative, including wrap of PC
    for (int v = 0; v < 256; v++) begin
      op = 8'h8D; o0 = 8'(v);
      pc = (v % 2 == 0) ? 16'hFFF0 : 16'h0008;
      call_chk("R4", 16'(pc + 16'd2 + (o0[7] ? {8'hFF, o0} : {8'h00, o0})), 16'(pc + 2));
    end
    // R12 call at sp=0
    sp = 16'h0000; op = 8'h9D; o0 = 8'h77; pc = 16'h2000;
    call_chk("R12 call wrap", 16'h0077, 16'h2002);
    check("R12 sp wrap", sp_o, 16'hFFFE);

    // R6 returns, with wrap
    foreach (sp_set[k]) ;
    for (int k = 0; k < 3; k++) begin
      sp = (k == 0) ? 16'h0030 : (k == 1) ? 16'hFFFE : 16'hFFFF;
      mem[8'(sp + 1)] = 8'hA0 + 8'(k); mem[8'(sp + 2)] = 8'h1B + 8'(k);
      op = 8'h39; run(cyc);
      check("R6 pc", pc_o, {8'hA0 + 8'(k), 8'h1B + 8'(k)});
      check("R6/R12 sp", sp_o, 16'(sp + 2));
      check("R6 cycles", cyc, 3);
    end

    // R7/R8 software interrupt
    for (int k = 0; k < 2; k++) begin
      sp = (k == 0) ? 16'h00F0 : 16'h0004;
      pc = 16'h3456 + 16'(k); cc = 8'hC1 + 8'(k * 2); ra = 8'h11; rb = 8'h22;
      ix = 16'h5566; iy = 16'h7788; op = 8'h3F;
      run(cyc);
      frame_chk("R7", sp, 16'(pc + 1));
      check("R8 cc mask", cc_o, cc | 8'h10);
      check("R8 vector", pc_o, 16'hC35A);
      check("R8 cycles", cyc, 12);
    end

    // R9 return from interrupt
    for (int k = 0; k < 3; k++) begin
      sp = (k == 0) ? 16'h0030 : (k == 1) ? 16'hFFFB : 16'hFFF8;
      for (int j = 1; j <= 9; j++) mem[8'(sp + 16'(j))] = 8'(8'h10 * j + k);
      op = 8'h3B; run(cyc);
      check("R9 cc", cc_o, 8'(8'h10 + k));
      check("R9 b",  b_o,  8'(8'h20 + k));
      check("R9 a",  a_o,  8'(8'h30 + k));
      check("R9 ix", ix_o, {8'(8'h40 + k), 8'(8'h50 + k)});
      check("R9 iy", iy_o, {8'(8'h60 + k), 8'(8'h70 + k)});
      check("R9 pc", pc_o, {8'(8'h80 + k), 8'(8'h90 + k)});
      check("R9/R12 sp", sp_o, 16'(sp + 9));
      check("R9 cycles", cyc, 10);
    end

    // R10 wait for interrupt
    sp = 16'h00F0; pc = 16'h6000; cc = 8'h00; op = 8'h3E; irq = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (9) @(negedge clk);
    w0 = nwr;
    repeat (20) @(negedge clk);
    check("R10 busy while waiting", busy, 1);
    check("R10 no done while waiting", done, 0);
    check("R10 no access while waiting", {we, re, 8'(nwr - w0)}, 0);
    irq = 1'b1; cyc = 0;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    irq = 1'b0;
    check("R10 cycles after irq", cyc, 3);
    frame_chk("R10", sp, 16'h6001);
    check("R10 cc mask", cc_o, 8'h10);
    check("R10 vector", pc_o, 16'hC35A);

    // R11 unknown opcodes
    for (int k = 0; k < 2; k++) begin
      sp = 16'h1357; pc = 16'h2468; w0 = nwr;
      op = (k == 0) ? 8'h12 : 8'h9D; pfx = (k == 1);
      run(cyc);
      check("R11 none cycles", cyc, 1);
      check("R11 none pc", pc_o, pc);
      check("R11 none sp", sp_o, sp);
      check("R11 none writes", nwr - w0, 0);
    end
    pfx = 0;
    @(negedge clk);
    check("R11 idle after done", {busy, done}, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  int sp_set [1];
endmodule